// File: doc/BRIEF.md
# SAR ADC busy-indicator read controller

This block sits on the host side of an 18-bit successive-approximation converter that is wired in three-wire chip-select mode, with its serial input strapped high and the turbo setting low. A start request raises the convert line for a fixed number of cycles and then drops it and holds it low. The converter floats its serial output during conversion, and a pull-up keeps the line high. When the conversion ends, the converter drives the line low. The controller takes this falling level, after a two-flop synchronizer, as the data-ready signal and starts its serial clock.

The serial clock comes from the system clock through a run-time divider. The converter moves its output on each falling serial-clock edge. The controller captures each bit at the next falling edge, so the 18 bits arrive MSB first on falls 2 to 19. The 19th period always runs inside the controller. A configuration input decides whether its pulse reaches the pin: the fall of that pulse sends the converter's output back to high impedance. The captured word is shown with a one-cycle valid strobe. A busy output covers the whole span from the accepted start to that strobe.

Two guard timers protect the converter. If the data line has not gone low within the longest conversion time plus a margin, the controller gives up and pulses a timeout flag. The convert line is also never raised again sooner than the longest conversion time after its previous rise. Start requests made while busy are dropped.

Top module: `sar_busy_reader`

## Requirements
- R1: After reset, cnv_o, sclk_o, valid_o, busy_o and timeout_o are 0 and data_o is all zeros.
- R2: A start accepted in idle raises cnv_o and busy_o on the same cycle. cnv_o stays high for exactly CNVH_CYC cycles and then stays low until the next accepted start. cnv_o is never high while busy_o is low.
- R3: start_i is ignored while busy_o is high: a request made during a readout causes no further cnv_o pulse and leaves the captured word intact.
- R4: No serial-clock pulse is issued before the synchronized data line reads low after the convert pulse, and sclk_o is low while cnv_o is high.
- R5: The word is assembled MSB first. Bit 17 is the value on sdo_i at the 2nd falling sclk edge, and bit 0 is the value at the 19th internal falling edge. It appears on data_o with valid_o high for exactly one cycle, and busy_o falls in that same cycle.
- R6: Each sclk_o high phase and each low phase lasts sclk_div_i + 1 system cycles.
- R7: With xtra_edge_i at 1, sclk_o gives 19 pulses per readout. With xtra_edge_i at 0, it gives 18 pulses, and the 19th period passes with sclk_o held low.
- R8: If the data line is still high TMO_MARGIN + CONV_MAX_CYC cycles after cnv_o rose, timeout_o pulses in exactly that cycle, counted from the rise cycle as 0. busy_o falls with it, no valid_o is produced, and the block returns to idle and accepts the next start.
- R9: Two rising edges of cnv_o are always at least CONV_MAX_CYC cycles apart. The valid strobe is held back until this holds.
- R10: sclk_o is low whenever busy_o is low.

Parameter constraints: CNVH_CYC is 3 or more and below CONV_MIN_CYC, and CONV_MIN_CYC is at most CONV_MAX_CYC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one conversion and readout |
| xtra_edge_i | input | 1 | 1: issue the 19th sclk pulse to release the data line |
| sclk_div_i | input | DIV_W | Serial clock half-period minus one, in system cycles |
| sdo_i | input | 1 | Converter serial data line (pulled up) |
| cnv_o | output | 1 | Convert line to the converter |
| sclk_o | output | 1 | Serial clock to the converter |
| data_o | output | DATA_W | Last captured conversion word |
| valid_o | output | 1 | One-cycle strobe: data_o holds a new word |
| busy_o | output | 1 | High from accepted start until valid or timeout |
| timeout_o | output | 1 | One-cycle strobe: data line never went low |

## Verification
The checks on convert spacing, strobe shape and clock quietness assume that sdo_i behaves like the converter. It floats high from the convert rise until the conversion ends, is then driven low, and changes only after serial-clock falls. They also assume that sclk_div_i and xtra_edge_i do not change during a readout. The bench converter model updates its output one system cycle after each observed sclk fall and releases the line when it sees a convert rise. The bench changes divider and extra-edge settings only between readouts. Start requests made during a readout are deliberate stimulus, used to exercise the ignore rule.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_CNVH = 3'd1,
    ST_WAIT = 3'd2,
    ST_READ = 3'd3,
    ST_HOLD = 3'd4
  } sbr_state_e;
endpackage

// File: rtl/sbr_sync.sv
module sbr_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) ff_q <= RST_VAL;
        else     ff_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) ff_q <= {STAGES{RST_VAL}};
        else     ff_q <= {ff_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/sbr_sclk_gen.sv
module sbr_sclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             mute_i,
  output logic             sclk_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             phase_q;
  logic             out_q;
  logic             term;

  // a phase ends when the counter reaches the programmed half-period
  assign term = run_i && (cnt_q == div_i);

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
      out_q   <= 1'b0;
    end else if (term) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
      out_q   <= ~phase_q & ~mute_i;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  // internal falling point: this edge ends a high phase
  assign fall_o = term && phase_q;
  assign sclk_o = out_q;
endmodule

// File: rtl/sbr_shift.sv
module sbr_shift #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] word_o
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) sh_q <= '0;
    else if (en_i)    sh_q <= {sh_q[W-2:0], bit_i};
  end

  assign word_o = sh_q;
endmodule

// File: rtl/sar_busy_reader.sv
module sar_busy_reader
  import sbr_pkg::*;
#(
  parameter int DATA_W       = 18,
  parameter int DIV_W        = 8,
  parameter int CNVH_CYC     = 4,
  parameter int CONV_MIN_CYC = 30,
  parameter int CONV_MAX_CYC = 60,
  parameter int TMO_MARGIN   = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              xtra_edge_i,
  input  logic [DIV_W-1:0]  sclk_div_i,
  input  logic              sdo_i,
  output logic              cnv_o,
  output logic              sclk_o,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              busy_o,
  output logic              timeout_o
);
  localparam int TMO_LIM = CONV_MAX_CYC + TMO_MARGIN;
  localparam int TMR_W   = $clog2(TMO_LIM + 1);
  localparam int PC_W    = $clog2(DATA_W + 2);
  localparam logic [TMR_W-1:0] CNVH_END = TMR_W'(CNVH_CYC - 1);
  localparam logic [TMR_W-1:0] TMO_END  = TMR_W'(TMO_LIM - 1);
  localparam logic [TMR_W-1:0] HOLD_END = TMR_W'(CONV_MAX_CYC - 1);
  localparam logic [TMR_W-1:0] TMR_SAT  = TMR_W'(TMO_LIM);
  localparam logic [PC_W-1:0]  LAST_PC  = PC_W'(DATA_W);

  sbr_state_e        state_q;
  logic [TMR_W-1:0]  timer_q;
  logic [PC_W-1:0]   falls_q;
  logic              cnv_q, busy_q, valid_q, tmo_q;
  logic [DATA_W-1:0] data_q;

  logic              sdo_sync;
  logic              run, mute, fall_evt;
  logic              accept, cap_en, last_fall;
  logic [DATA_W-1:0] shift_word;

  sbr_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (sdo_i),
    .q_o (sdo_sync)
  );

  assign run  = (state_q == ST_READ);
  assign mute = (falls_q == LAST_PC) && !xtra_edge_i;

  sbr_sclk_gen #(.DIV_W(DIV_W)) u_sclk (
    .clk    (clk),
    .rst    (rst),
    .run_i  (run),
    .div_i  (sclk_div_i),
    .mute_i (mute),
    .sclk_o (sclk_o),
    .fall_o (fall_evt)
  );

  assign accept    = (state_q == ST_IDLE) && start_i;
  assign cap_en    = fall_evt && (falls_q != '0);
  assign last_fall = fall_evt && (falls_q == LAST_PC);

  sbr_shift #(.W(DATA_W)) u_shift (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (accept),
    .en_i   (cap_en),
    .bit_i  (sdo_i),
    .word_o (shift_word)
  );

  // one timer from the convert rise serves pulse width, timeout and hold
  always_ff @(posedge clk) begin
    if (rst || state_q == ST_IDLE) timer_q <= '0;
    else if (timer_q != TMR_SAT)   timer_q <= timer_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      falls_q <= '0;
      cnv_q   <= 1'b0;
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
      tmo_q   <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= 1'b0;
      tmo_q   <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_CNVH;
            cnv_q   <= 1'b1;
            busy_q  <= 1'b1;
          end
        end
        ST_CNVH: begin
          if (timer_q == CNVH_END) begin
            cnv_q   <= 1'b0;
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (!sdo_sync) begin
            state_q <= ST_READ;
            falls_q <= '0;
          end else if (timer_q == TMO_END) begin
            tmo_q   <= 1'b1;
            busy_q  <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        ST_READ: begin
          if (fall_evt) falls_q <= falls_q + 1'b1;
          if (last_fall) state_q <= ST_HOLD;
        end
        ST_HOLD: begin
          if (timer_q >= HOLD_END) begin
            data_q  <= shift_word;
            valid_q <= 1'b1;
            busy_q  <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cnv_o     = cnv_q;
  assign busy_o    = busy_q;
  assign valid_o   = valid_q;
  assign timeout_o = tmo_q;
  assign data_o    = data_q;
endmodule

// File: rtl/sbr_checker.sv
module sbr_checker #(
  parameter int CONV_MAX_CYC = 60
) (
  input logic clk,
  input logic rst,
  input logic cnv_o,
  input logic sclk_o,
  input logic valid_o,
  input logic busy_o,
  input logic timeout_o
);
  localparam int GAP_W = $clog2(CONV_MAX_CYC + 1);
  localparam logic [GAP_W-1:0] GAP_SAT = GAP_W'(CONV_MAX_CYC);
  localparam logic [GAP_W-1:0] GAP_MIN = GAP_W'(CONV_MAX_CYC - 1);

  logic             cnv_d, busy_d;
  logic [GAP_W-1:0] gap_q;
  logic             cnv_rise;

  assign cnv_rise = cnv_o && !cnv_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnv_d  <= 1'b0;
      busy_d <= 1'b0;
      gap_q  <= GAP_SAT;
    end else begin
      cnv_d  <= cnv_o;
      busy_d <= busy_o;
      if (cnv_rise)             gap_q <= '0;
      else if (gap_q != GAP_SAT) gap_q <= gap_q + 1'b1;
    end
  end

  AST_CNV_SPACING: assert property (@(posedge clk) disable iff (rst) cnv_rise |-> gap_q >= GAP_MIN); // R9
  AST_CNV_IN_BUSY: assert property (@(posedge clk) disable iff (rst) cnv_o |-> busy_o); // R2
  AST_CNV_ON_NEW_START: assert property (@(posedge clk) disable iff (rst) cnv_rise |-> !busy_d); // R3
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) valid_o |=> !valid_o); // R5
  AST_BUSY_END_CAUSE: assert property (@(posedge clk) disable iff (rst) (busy_d && !busy_o) |-> (valid_o || timeout_o)); // R5
  AST_SCLK_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst) !busy_o |-> !sclk_o); // R10
  AST_SCLK_NOT_IN_CNV: assert property (@(posedge clk) disable iff (rst) cnv_o |-> !sclk_o); // R4
  AST_TMO_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) timeout_o |-> (!valid_o && !busy_o)); // R8
endmodule

bind sar_busy_reader sbr_checker #(.CONV_MAX_CYC(CONV_MAX_CYC)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .cnv_o     (cnv_o),
  .sclk_o    (sclk_o),
  .valid_o   (valid_o),
  .busy_o    (busy_o),
  .timeout_o (timeout_o)
);

// File: tb/sar_busy_reader_tb_top.sv
module sar_busy_reader_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW   = 18;
  localparam int CNVH = 4;
  localparam int CMIN = 30;
  localparam int CMAX = 120;
  localparam int MARG = 20;
  localparam int TMO  = CMAX + MARG;
  localparam int NVEC = 6;

  // fields: word[30:13] conv_cycles[12:5] div[4:1] extra_edge[0]
  localparam logic [30:0] VEC [NVEC] = '{
    {18'h2A5C3, 8'd35,  4'd0, 1'b0},
    {18'h3FFFF, 8'd60,  4'd1, 1'b1},
    {18'h00000, 8'd90,  4'd2, 1'b0},
    {18'h20001, 8'd45,  4'd3, 1'b1},
    {18'h1B6D9, 8'd100, 4'd0, 1'b1},
    {18'h15555, 8'd31,  4'd5, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          xtra = 1'b0;
  logic [7:0]    sdiv = 8'd0;
  logic          sdo = 1'b1;
  logic          cnv, sclk, valid, busy, tmo;
  logic [DW-1:0] data;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sar_busy_reader #(
    .DATA_W(DW), .DIV_W(8), .CNVH_CYC(CNVH),
    .CONV_MIN_CYC(CMIN), .CONV_MAX_CYC(CMAX), .TMO_MARGIN(MARG)
  ) dut_i (
    .clk(clk), .rst(rst), .start_i(start), .xtra_edge_i(xtra),
    .sclk_div_i(sdiv), .sdo_i(sdo), .cnv_o(cnv), .sclk_o(sclk),
    .data_o(data), .valid_o(valid), .busy_o(busy), .timeout_o(tmo)
  );

  // converter model
  logic [DW-1:0] cur_word = '0;
  int            cur_conv = 40;
  logic          adc_hang = 1'b0;
  logic          conv_armed = 1'b0;
  logic          cnv_p = 1'b0, sclk_p = 1'b0;
  int            conv_cnt = 0, bit_k = 0;

  always @(posedge clk) begin
    if (cnv && !cnv_p) begin
      sdo <= 1'b1; bit_k = 0; conv_cnt = 0; conv_armed = !adc_hang;
    end else if (conv_armed) begin
      conv_cnt++;
      if (conv_cnt >= cur_conv) begin sdo <= 1'b0; conv_armed = 1'b0; end
    end
    if (sclk_p && !sclk) begin
      bit_k++;
      if (bit_k <= DW) sdo <= cur_word[DW-bit_k];
      else             sdo <= 1'b1;
    end
    cnv_p  <= cnv;
    sclk_p <= sclk;
  end

  // monitor, sampled away from the active edge
  int   cyc = 0;
  int   exp_half = 1;
  int   cnv_rises = 0, sclk_rises = 0, width_bad = 0, early_sclk = 0;
  int   last_cnvh = 0, cnvh_run = 0, hi_run = 0;
  int   last_rise_cyc = -1, min_gap = 1000000;
  logic cnv_m = 1'b0, sclk_m = 1'b0;

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (!rst) begin
      if (cnv && !cnv_m) begin
        cnv_rises++;
        if (last_rise_cyc >= 0 && (cyc - last_rise_cyc) < min_gap) min_gap = cyc - last_rise_cyc;
        last_rise_cyc = cyc;
      end
      if (cnv) cnvh_run++;
      else if (cnv_m) begin last_cnvh = cnvh_run; cnvh_run = 0; end
      if (sclk && !sclk_m) begin
        sclk_rises++;
        if (conv_armed || adc_hang) early_sclk++;
      end
      if (sclk) hi_run++;
      else if (sclk_m) begin
        if (hi_run != exp_half) width_bad++;
        hi_run = 0;
      end
    end
    cnv_m  = cnv;
    sclk_m = sclk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_vec(input logic [DW-1:0] w, input int conv, input int dv, input bit ext);
    int  r0, s0, wb0, e0, n;
    bit  got_v, inj;
    cur_word = w; cur_conv = conv; sdiv = 8'(dv); xtra = ext; exp_half = dv + 1;
    r0 = cnv_rises; s0 = sclk_rises; wb0 = width_bad; e0 = early_sclk;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    got_v = 1'b0; inj = 1'b0; n = 0;
    while (!got_v && n < 20000) begin
      @(negedge clk);
      n++;
      if (start) start = 1'b0;
      if (valid) got_v = 1'b1;
      else if (!inj && sclk_rises != s0) begin start = 1'b1; inj = 1'b1; end
    end
    chk(got_v, "R5 valid seen", int'(got_v), 1);
    chk(data == w, "R5 data word", int'(data), int'(w));
    chk(!busy, "R5 busy falls with valid", int'(busy), 0);
    chk((sclk_rises - s0) == (ext ? 19 : 18), "R7 pulse count", sclk_rises - s0, ext ? 19 : 18);
    chk(width_bad == wb0, "R6 sclk phase width", width_bad - wb0, 0);
    chk(last_cnvh == CNVH, "R2 convert pulse width", last_cnvh, CNVH);
    chk(early_sclk == e0, "R4 no sclk before ready", early_sclk - e0, 0);
    chk((cnv_rises - r0) == 1, "R3 start during readout ignored", cnv_rises - r0, 1);
    @(negedge clk);
    chk(!valid, "R5 valid lasts one cycle", int'(valid), 0);
    chk(!sclk, "R10 sclk low when idle", int'(sclk), 0);
  endtask

  initial begin
    int  n;
    bit  got_t, saw_v;
    repeat (5) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    chk(!cnv, "R1 cnv reset", int'(cnv), 0);
    chk(!sclk, "R1 sclk reset", int'(sclk), 0);
    chk(!valid && !tmo, "R1 strobes reset", int'({valid, tmo}), 0);
    chk(!busy, "R1 busy reset", int'(busy), 0);
    chk(data == '0, "R1 data reset", int'(data), 0);

    // first start: cnv and busy rise together
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(cnv && busy, "R2 cnv and busy rise on start", int'({cnv, busy}), 3);
    n = 0;
    while (!valid && n < 5000) begin @(negedge clk); n++; end
    @(negedge clk);

    for (int i = 0; i < NVEC; i++)
      run_vec(VEC[i][30:13], int'(VEC[i][12:5]), int'(VEC[i][4:1]), VEC[i][0]);

    // timeout: converter never signals ready
    adc_hang = 1'b1;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    got_t = 1'b0; saw_v = 1'b0; n = 0;
    while (!got_t && n < 3000) begin
      @(negedge clk);
      n++;
      if (valid) saw_v = 1'b1;
      if (tmo) got_t = 1'b1;
    end
    chk(got_t, "R8 timeout pulse", int'(got_t), 1);
    chk((cyc - last_rise_cyc) == TMO, "R8 timeout cycle", cyc - last_rise_cyc, TMO);
    chk(!saw_v && !busy, "R8 no valid and busy dropped", int'({saw_v, busy}), 0);
    chk(early_sclk == 0, "R4 no sclk while line high", early_sclk, 0);
    @(negedge clk);
    chk(!tmo, "R8 timeout one cycle", int'(tmo), 0);
    adc_hang = 1'b0;

    run_vec(18'h0F0F0, 50, 1, 1'b0); // R8 recovery after timeout

    chk(min_gap >= CMAX, "R9 convert rise spacing", min_gap, CMAX);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule